// File: doc/BRIEF.md
# Process Descriptor Dispatch Unit

This block starts a process from a 16-bit process number. The process number is the byte address of a 32-bit descriptor, which is kept in memory as two 16-bit words. Requests come from three places. A write to a device register supplies the register address. An interrupt supplies its vector address. A return-from-interrupt supplies the current stack pointer, so the descriptor is read from the top of the stack. All three sources address the descriptor in the same way, and the source code is returned with the result.

The block reads both descriptor words through a request/acknowledge memory port and splits them into type, function, extended flag, status and location. The next step depends on the type:

- A plain processor process takes its location as the new program counter.
- An extended processor process reads a ten-word context block starting at its location. Each word read is written to the register file.
- An I/O process is passed to an I/O engine with the decoded fields. No context is read.

Top module: `pd_dispatch`

## Requirements
- R1: After reset, busy_o, done_o, mem_req_o, rf_we_o, io_start_o and map_load_o are all 0.
- R2: A request (req_valid_i=1) is accepted only while busy_o=0. busy_o stays 1 until the dispatch ends. A request made while busy_o=1 is ignored: it causes no memory read and does not change the result.
- R3: The descriptor is read as two words: first the word at the process number N, then the word at N+2 (16-bit wrap). mem_req_o stays high with a stable mem_addr_o until mem_ack_i is seen. mem_rdata_i is taken in the cycle of the acknowledge.
- R4: Field layout of the word at N:
  - bits [15:14] are type_o (00 kernel, 01 user, 10 supervisor, 11 I/O);
  - bits [13:11] are func_o;
  - bit [10] is ext_o;
  - bits [7:0] are status_o.
  
  The word at N+2 is loc_o. All of these are valid while done_o=1.
- R5: A processor process (type not 11) with ext=0 sets pc_o to loc. It makes no register-file writes, and map_load_o is 0.
- R6: A processor process with ext=1 reads ten words at loc, loc+2, …, loc+18. One cycle after each acknowledge, rf_we_o pulses with rf_data_o set to the word read. The rf_idx_o value for each word is:

  | Word | Contents | rf_idx_o |
  |---|---|---|
  | 1 | previous map address | 8 |
  | 2 | current map address | 9 |
  | 3 to 9 | R0 to R6 | 0 to 6 |
  | 10 | program counter | 7 |

  pc_o equals the tenth word.
- R7: map_load_o pulses together with done_o only for an extended processor process whose current map address word is non-zero. If that word is zero, map loading is suppressed and map_load_o stays 0.
- R8: An I/O process (type 11) never reads a context block, whatever its ext bit. io_start_o pulses together with done_o, and pc_o is 0.
- R9: done_o is a one-cycle pulse in the cycle after the final acknowledge. src_o echoes the accepted req_src_i (0 device register, 1 interrupt, 2 return).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Dispatch request |
| req_src_i | input | 2 | Request source code |
| req_num_i | input | 16 | Process number (descriptor address) |
| busy_o | output | 1 | Dispatch in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory byte address |
| mem_ack_i | input | 1 | Memory acknowledge, data valid |
| mem_rdata_i | input | 16 | Memory read data |
| done_o | output | 1 | Dispatch complete pulse |
| src_o | output | 2 | Source of completed request |
| type_o | output | 2 | Process type |
| func_o | output | 3 | Function field |
| ext_o | output | 1 | Extended-context flag |
| status_o | output | 8 | Status field |
| loc_o | output | 16 | Location field |
| pc_o | output | 16 | New program counter |
| map_load_o | output | 1 | Map load requested |
| io_start_o | output | 1 | Hand-off strobe to I/O engine |
| rf_we_o | output | 1 | Register-file write strobe |
| rf_idx_o | output | 4 | Register-file index |
| rf_data_o | output | 16 | Register-file write data |

## Verification
The case that is hardest to reach is a second request arriving in the middle of a context-block walk. To reach it, the bench gives the memory model a two-cycle acknowledge latency on an extended process and raises req_valid_i a few cycles into that dispatch. Any read that the stray request caused would show up as an address mismatch in the expected read queue.

A second corner is a context block that runs past address 0xFFFE. It is reached by placing the location at 0xFFF8, with a zero current-map word so that the suppressed map load is checked in the same dispatch.

// File: rtl/pd_pkg.sv
package pd_pkg;
  localparam int unsigned ADDR_W    = 16;
  localparam int unsigned DATA_W    = 16;
  localparam int unsigned CTX_WORDS = 10;
  localparam int unsigned RIDX_W    = 4;

  typedef enum logic [1:0] {S_IDLE, S_HI, S_LO, S_CTX} seq_state_e;

  typedef enum logic [1:0] {
    PT_KERN = 2'b00,
    PT_USER = 2'b01,
    PT_SUPV = 2'b10,
    PT_IO   = 2'b11
  } ptype_e;

  typedef struct packed {
    ptype_e     ptype;
    logic [2:0] func;
    logic       ext;
    logic [7:0] status;
  } desc_hi_t;

  // context word order -> register-file index
  function automatic int unsigned ctx_to_ridx(int unsigned w);
    if (w == 0)                  return 8;
    else if (w == 1)             return 9;
    else if (w == CTX_WORDS - 1) return 7;
    else                         return w - 2;
  endfunction
endpackage

// File: rtl/pd_decode.sv
module pd_decode
  import pd_pkg::*;
(
  input  logic [DATA_W-1:0] word_i,
  output desc_hi_t          hi_o
);
  logic unused_rsvd;
  assign unused_rsvd = ^word_i[9:8];

  always_comb begin
    hi_o.ptype  = ptype_e'(word_i[15:14]);
    hi_o.func   = word_i[13:11];
    hi_o.ext    = word_i[10];
    hi_o.status = word_i[7:0];
  end
endmodule

// File: rtl/pd_seq.sv
module pd_seq
  import pd_pkg::*;
#(
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned NCTX  = CTX_WORDS,
  parameter int unsigned CNT_W = $clog2(NCTX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [AW-1:0]    num_i,
  input  logic             go_ctx_i,
  input  logic             mem_ack_i,
  input  logic [DW-1:0]    mem_rdata_i,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic             busy_o,
  output logic             hi_ack_o,
  output logic             lo_ack_o,
  output logic             ctx_ack_o,
  output logic [CNT_W-1:0] ctx_idx_o,
  output logic             finish_o,
  output logic [AW-1:0]    loc_o
);
  seq_state_e       state_q;
  logic [AW-1:0]    num_q, loc_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_ctx;

  assign busy_o    = state_q != S_IDLE;
  assign mem_req_o = busy_o;
  assign hi_ack_o  = (state_q == S_HI)  && mem_ack_i;
  assign lo_ack_o  = (state_q == S_LO)  && mem_ack_i;
  assign ctx_ack_o = (state_q == S_CTX) && mem_ack_i;
  assign ctx_idx_o = cnt_q;
  assign last_ctx  = cnt_q == CNT_W'(NCTX - 1);
  assign finish_o  = (lo_ack_o && !go_ctx_i) || (ctx_ack_o && last_ctx);
  assign loc_o     = loc_q;

  always_comb begin
    unique case (state_q)
      S_LO:    mem_addr_o = num_q + AW'(2);
      S_CTX:   mem_addr_o = loc_q + (AW'(cnt_q) << 1);
      default: mem_addr_o = num_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      num_q   <= '0;
      loc_q   <= '0;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          state_q <= S_HI;
          num_q   <= num_i;
        end
        S_HI: if (mem_ack_i) state_q <= S_LO;
        S_LO: if (mem_ack_i) begin
          loc_q   <= AW'(mem_rdata_i);
          cnt_q   <= '0;
          state_q <= go_ctx_i ? S_CTX : S_IDLE;
        end
        S_CTX: if (mem_ack_i) begin
          if (last_ctx) state_q <= S_IDLE;
          else          cnt_q   <= cnt_q + CNT_W'(1);
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pd_ctx_load.sv
module pd_ctx_load
  import pd_pkg::*;
#(
  parameter int unsigned DW    = DATA_W,
  parameter int unsigned CNT_W = 4,
  parameter int unsigned IW    = RIDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             ctx_ack_i,
  input  logic [CNT_W-1:0] ctx_idx_i,
  input  logic [DW-1:0]    data_i,
  output logic             rf_we_o,
  output logic [IW-1:0]    rf_idx_o,
  output logic [DW-1:0]    rf_data_o,
  output logic             curmap_nz_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rf_we_o     <= 1'b0;
      rf_idx_o    <= '0;
      rf_data_o   <= '0;
      curmap_nz_o <= 1'b0;
    end else begin
      rf_we_o <= ctx_ack_i;
      if (clr_i) curmap_nz_o <= 1'b0;
      if (ctx_ack_i) begin
        rf_idx_o  <= IW'(ctx_to_ridx(int'(ctx_idx_i)));
        rf_data_o <= data_i;
        if (ctx_idx_i == CNT_W'(1)) curmap_nz_o <= |data_i;
      end
    end
  end
endmodule

// File: rtl/pd_dispatch.sv
module pd_dispatch
  import pd_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned DATA_BITS = DATA_W,
  parameter int unsigned NCTX      = CTX_WORDS,
  parameter int unsigned IDX_BITS  = RIDX_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  input  logic [1:0]           req_src_i,
  input  logic [ADDR_BITS-1:0] req_num_i,
  output logic                 busy_o,
  output logic                 mem_req_o,
  output logic [ADDR_BITS-1:0] mem_addr_o,
  input  logic                 mem_ack_i,
  input  logic [DATA_BITS-1:0] mem_rdata_i,
  output logic                 done_o,
  output logic [1:0]           src_o,
  output logic [1:0]           type_o,
  output logic [2:0]           func_o,
  output logic                 ext_o,
  output logic [7:0]           status_o,
  output logic [ADDR_BITS-1:0] loc_o,
  output logic [DATA_BITS-1:0] pc_o,
  output logic                 map_load_o,
  output logic                 io_start_o,
  output logic                 rf_we_o,
  output logic [IDX_BITS-1:0]  rf_idx_o,
  output logic [DATA_BITS-1:0] rf_data_o
);
  localparam int unsigned CNT_W = $clog2(NCTX);

  desc_hi_t         dec, hi_q;
  logic             start, go_ctx, is_io;
  logic             hi_ack, lo_ack, ctx_ack, finish, curmap_nz;
  logic [CNT_W-1:0] ctx_idx;
  logic             done_q, map_q, io_q;
  logic [1:0]       src_q;
  logic [DATA_BITS-1:0] pc_q;

  assign start  = req_valid_i && !busy_o;
  assign is_io  = hi_q.ptype == PT_IO;
  assign go_ctx = hi_q.ext && !is_io;

  pd_decode u_decode (.word_i(mem_rdata_i), .hi_o(dec));

  pd_seq #(.AW(ADDR_BITS), .DW(DATA_BITS), .NCTX(NCTX), .CNT_W(CNT_W)) u_seq (
    .clk_i, .rst_ni,
    .start_i    (start),
    .num_i      (req_num_i),
    .go_ctx_i   (go_ctx),
    .mem_ack_i,
    .mem_rdata_i,
    .mem_req_o,
    .mem_addr_o,
    .busy_o,
    .hi_ack_o   (hi_ack),
    .lo_ack_o   (lo_ack),
    .ctx_ack_o  (ctx_ack),
    .ctx_idx_o  (ctx_idx),
    .finish_o   (finish),
    .loc_o
  );

  pd_ctx_load #(.DW(DATA_BITS), .CNT_W(CNT_W), .IW(IDX_BITS)) u_ctx (
    .clk_i, .rst_ni,
    .clr_i       (start),
    .ctx_ack_i   (ctx_ack),
    .ctx_idx_i   (ctx_idx),
    .data_i      (mem_rdata_i),
    .rf_we_o,
    .rf_idx_o,
    .rf_data_o,
    .curmap_nz_o (curmap_nz)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q   <= '0;
      src_q  <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
      map_q  <= 1'b0;
      io_q   <= 1'b0;
    end else begin
      done_q <= finish;
      map_q  <= finish && go_ctx && curmap_nz;
      io_q   <= finish && is_io;
      if (start)  src_q <= req_src_i;
      if (hi_ack) hi_q  <= dec;
      // final word in flight is LOC (plain) or context PC (extended)
      if (finish) pc_q  <= is_io ? '0 : mem_rdata_i;
    end
  end

  assign done_o     = done_q;
  assign src_o      = src_q;
  assign type_o     = hi_q.ptype;
  assign func_o     = hi_q.func;
  assign ext_o      = hi_q.ext;
  assign status_o   = hi_q.status;
  assign pc_o       = pc_q;
  assign map_load_o = map_q;
  assign io_start_o = io_q;
endmodule

// File: rtl/pd_dispatch_chk.sv
module pd_dispatch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        mem_req_o,
  input logic [15:0] mem_addr_o,
  input logic        mem_ack_i,
  input logic        done_o,
  input logic [1:0]  type_o,
  input logic        ext_o,
  input logic        map_load_o,
  input logic        io_start_o,
  input logic        rf_we_o,
  input logic [3:0]  rf_idx_o
);
  a_r3_hold_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o));

  a_r2_req_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_rf_idx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> rf_idx_o <= 4'd9);

  a_r7_map_ext_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_load_o |-> done_o && ext_o && type_o != 2'b11);

  a_r8_io_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_start_o |-> done_o && type_o == 2'b11 && !map_load_o);
endmodule

bind pd_dispatch pd_dispatch_chk u_chk (.*);

// File: tb/test_pd_dispatch.sv
module test_pd_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_src = '0;
  logic [15:0] req_num = '0;
  logic        busy, mem_req, mem_ack = 1'b0, done, ext, map_load, io_start, rf_we;
  logic [15:0] mem_addr, mem_rdata = '0, loc, pc, rf_data;
  logic [1:0]  src, ptype;
  logic [2:0]  func;
  logic [7:0]  status;
  logic [3:0]  rf_idx;

  always #10 clk = ~clk;

  pd_dispatch i_pd_dispatch (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_src_i(req_src),
    .req_num_i(req_num), .busy_o(busy), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata), .done_o(done), .src_o(src),
    .type_o(ptype), .func_o(func), .ext_o(ext), .status_o(status), .loc_o(loc),
    .pc_o(pc), .map_load_o(map_load), .io_start_o(io_start), .rf_we_o(rf_we),
    .rf_idx_o(rf_idx), .rf_data_o(rf_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [15:0] mem [int];
  logic [15:0] exp_addr [$];
  logic [3:0]  exp_idx  [$];
  logic [15:0] exp_dat  [$];
  logic [1:0]  e_src, e_type;
  logic [2:0]  e_func;
  logic        e_ext, e_map, e_io;
  logic [7:0]  e_status;
  logic [15:0] e_loc, e_pc;
  int done_seen = 0;
  int lat = 0, wcnt = 0;
  bit prev_done = 0;

  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0;
  endfunction

  function automatic logic [15:0] hiw(logic [1:0] t, logic [2:0] f, logic e, logic [7:0] s);
    return {t, f, e, 2'b00, s};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // memory model: ack after lat wait cycles, one-cycle ack, checks read order (R3, R6)
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0; wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack   = 1'b1;
        mem_rdata = rd(mem_addr);
        if (exp_addr.size() == 0) chk("R3", "unexpected read", 32'(mem_addr), 32'hFFFFFFFF);
        else chk("R3", "read address", 32'(mem_addr), 32'(exp_addr.pop_front()));
      end else wcnt++;
    end
  end

  // output monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (rf_we) begin
        if (exp_idx.size() == 0) chk("R6", "unexpected rf write", 32'(rf_idx), 32'hFFFFFFFF);
        else begin
          chk("R6", "rf index", 32'(rf_idx), 32'(exp_idx.pop_front()));
          chk("R6", "rf data", 32'(rf_data), 32'(exp_dat.pop_front()));
        end
      end
      if (!done) begin
        chk("R7", "map_load without done", 32'(map_load), 0);
        chk("R8", "io_start without done", 32'(io_start), 0);
      end else begin
        chk("R9", "done pulse width", 32'(prev_done), 0);
        chk("R9", "src", 32'(src), 32'(e_src));
        chk("R4", "type", 32'(ptype), 32'(e_type));
        chk("R4", "func", 32'(func), 32'(e_func));
        chk("R4", "ext", 32'(ext), 32'(e_ext));
        chk("R4", "status", 32'(status), 32'(e_status));
        chk("R4", "loc", 32'(loc), 32'(e_loc));
        chk("R5", "pc", 32'(pc), 32'(e_pc));
        chk("R7", "map_load", 32'(map_load), 32'(e_map));
        chk("R8", "io_start", 32'(io_start), 32'(e_io));
        chk("R9", "reads done", 32'(exp_addr.size()), 0);
        done_seen++;
      end
      prev_done = done;
    end
  end

  task automatic run(logic [1:0] s, logic [15:0] n, int l, bit poke);
    logic [15:0] h, lc, a;
    bit go;
    int d0;
    h  = rd(n);
    lc = rd(n + 16'd2);
    exp_addr.push_back(n);
    exp_addr.push_back(n + 16'd2);
    go = h[10] && h[15:14] != 2'b11;
    if (go) begin
      for (int k = 0; k < 10; k++) begin
        a = lc + 16'(2 * k);
        exp_addr.push_back(a);
        exp_idx.push_back(k == 0 ? 4'd8 : k == 1 ? 4'd9 : k == 9 ? 4'd7 : 4'(k - 2));
        exp_dat.push_back(rd(a));
      end
    end
    e_src = s; e_type = h[15:14]; e_func = h[13:11]; e_ext = h[10]; e_status = h[7:0];
    e_loc = lc;
    e_io  = h[15:14] == 2'b11;
    e_pc  = go ? rd(lc + 16'd18) : (e_io ? 16'h0 : lc);
    e_map = go && rd(lc + 16'd2) != 16'h0;
    lat = l;
    d0 = done_seen;
    @(negedge clk);
    req_valid = 1'b1; req_src = s; req_num = n;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "busy after accept", 32'(busy), 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      chk("R2", "busy mid walk", 32'(busy), 1);
      req_valid = 1'b1; req_src = 2'd3; req_num = 16'h0040;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_seen == d0) @(negedge clk);
    chk("R6", "rf writes consumed", 32'(exp_idx.size()), 0);
    @(negedge clk);
    chk("R2", "idle after done", 32'(busy), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // kernel, plain
    mem[16'h0040] = hiw(2'b00, 3'd5, 1'b0, 8'hE4);
    mem[16'h0042] = 16'h1234;
    // user, plain, reached by return
    mem[16'h0F00] = hiw(2'b01, 3'd2, 1'b0, 8'h0F);
    mem[16'h0F02] = 16'h2000;
    // I/O with ext set: must not walk
    mem[16'hFF20] = hiw(2'b11, 3'd6, 1'b1, 8'h55);
    mem[16'hFF22] = 16'h3000;
    for (int k = 0; k < 10; k++) mem[16'h3000 + 2 * k] = 16'hBEEF;
    // supervisor, extended
    mem[16'h0080] = hiw(2'b10, 3'd1, 1'b1, 8'hA7);
    mem[16'h0082] = 16'h4000;
    mem[16'h4000] = 16'h7700;
    mem[16'h4002] = 16'h7720;
    for (int k = 0; k < 7; k++) mem[16'h4004 + 2 * k] = 16'h1000 + 16'(k);
    mem[16'h4012] = 16'h5555;
    // kernel, extended, zero current map, block wraps past 0xFFFE
    mem[16'h00C0] = hiw(2'b00, 3'd0, 1'b1, 8'h00);
    mem[16'h00C2] = 16'hFFF8;
    for (int k = 0; k < 10; k++) mem[int'(16'(16'hFFF8 + 16'(2 * k)))] = (k == 1) ? 16'h0 : 16'h9000 + 16'(k);

    repeat (3) @(negedge clk);
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "mem_req", 32'(mem_req), 0);
    chk("R1", "rf_we", 32'(rf_we), 0);
    chk("R1", "io_start", 32'(io_start), 0);
    chk("R1", "map_load", 32'(map_load), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(2'd1, 16'h0040, 0, 0); // R5 interrupt, kernel plain
    run(2'd2, 16'h0F00, 1, 0); // R5 return, user plain
    run(2'd0, 16'hFF20, 0, 0); // R8 device register, I/O
    run(2'd1, 16'h0080, 2, 1); // R6 R7 extended, map load, poke while busy (R2)
    run(2'd0, 16'h00C0, 0, 0); // R7 suppressed map load, wrap
    run(2'd1, 16'h0040, 1, 0); // R3 repeat after extended
    finish_run();
  end
endmodule